// File: doc/BRIEF.md
# Offset-Encoded PLL Divider Chain

This block holds the three digital dividers that sit around the analog core of a frequency-synthesizer loop. A reference pre-divider brings the input clock down to the comparison rate. A feedback divider divides the oscillator clock so that the phase detector can compare it against the divided reference. A post scaler divides the oscillator clock again to produce the clock the chip uses. Each divide ratio comes from a raw binary field with a fixed offset or a power-of-two mapping. The feedback ratio is the field plus 8, the reference ratio is the field plus 2, and the post ratio is two raised to the field. When the loop is locked, the output frequency is (M+8)·Fin / ((P+2)·2^S).

Each divider runs in the domain of its own clock. It reloads its ratio only at the end of a period, so the output never carries a shortened pulse. A single active-high power-down input is synchronised into both domains. While it is high, it holds every counter cleared and every output low. When it is released, each divider starts a fresh period on its own clock.

Top module: `pll_div_chain`

## Requirements
- R1: The feedback output `fb_div_o` has a period of `fb_sel_i`+8 oscillator rising edges (8 to 263), measured over a full period in the oscillator domain.
- R2: The reference output `ref_div_o` has a period of `pre_sel_i`+2 reference rising edges (2 to 65).
- R3: For `post_sel_i` = 1, 2 or 3, `out_clk_o` has a period of 2, 4 or 8 oscillator rising edges, high for the first half of each period.
- R4: For `post_sel_i` = 0, `out_clk_o` follows the oscillator clock: it is high while the clock is high and low while the clock is low.
- R5: For a period of n edges, the output is high for ceil(n/2) edges and low for floor(n/2) edges. The period starts with the high phase, so an odd ratio is off 50% duty by at most one input period.
- R6: A change to a select field during a period leaves the current period's length and shape unchanged. The new ratio applies from the next period onward.
- R7: While `pwrdn_i` is high, from the third rising edge of a domain's clock onward, that domain's outputs are low, whatever the select fields and the clock phase.
- R8: When `pwrdn_i` falls (or `rst_ni` rises with `pwrdn_i` low) before rising edge e1 of a domain, that domain's output stays low through e2. It goes high on e3, which starts the first period.
- R9: While `rst_ni` is low, all three outputs are low.
- R10: With M=85, P=42 and S=0, the feedback period is 93 oscillator edges, the reference period is 44 reference edges, and `out_clk_o` is the oscillator clock itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference input clock |
| osc_clk_i | input | 1 | Oscillator clock |
| pwrdn_i | input | 1 | Active-high power-down, synchronised into each domain |
| pre_sel_i | input | 6 | Reference divide field, ratio = field + 2 |
| fb_sel_i | input | 8 | Feedback divide field, ratio = field + 8 |
| post_sel_i | input | 2 | Post scale field, ratio = 2^field |
| ref_div_o | output | 1 | Divided reference clock |
| fb_div_o | output | 1 | Divided feedback clock |
| out_clk_o | output | 1 | Scaled output clock |

## Verification
A select field can change in the same cycle that the divider reaches its terminal count, which is where the divider loads its next ratio. The restart after power-down is a second point where the ratio is loaded, so both coincide with a field update. The bench changes fields while the block is halted, so that the first start edge loads them. It also changes a field in the middle of a period, and the period that wrapped in that same cycle must keep its old length. Each case is judged by comparing the output edge by edge against a model of the period sequence that is computed from the requirements.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  // bits needed to hold the largest ratio (2^field_w - 1 + ofs)
  function automatic int ratio_width(input int field_w, input int ofs);
    return $clog2((1 << field_w) + ofs);
  endfunction

  // number of high edges in a period of n edges
  function automatic int high_edges(input int n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/pll_pd_sync.sv
module pll_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic halt_o
);
  logic [STAGES-1:0] sync_q;

  // reset lands in the halted state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= (sync_q << 1) | STAGES'(pd_i);
  end

  assign halt_o = sync_q[STAGES-1];
endmodule

// File: rtl/pll_int_div.sv
module pll_int_div #(
  parameter int RW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic [RW-1:0] ratio_i,
  output logic          div_o
);
  logic          run_q;
  logic          div_q;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] n_q;
  logic [RW-1:0] cnt_inc;
  logic [RW:0]   hi_edges;
  logic          wrap;

  assign cnt_inc  = cnt_q + 1'b1;
  assign hi_edges = ({1'b0, n_q} + 1'b1) >> 1;
  assign wrap     = (cnt_inc == n_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      n_q   <= '1;
      div_q <= 1'b0;
    end else if (halt_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!run_q || wrap) begin
      // start of a period: ratio is loaded only here
      run_q <= 1'b1;
      cnt_q <= '0;
      n_q   <= ratio_i;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      div_q <= ({1'b0, cnt_inc} < hi_edges);
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/pll_post_scaler.sv
module pll_post_scaler #(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic [SW-1:0] scale_i,
  output logic          clk_o
);
  localparam int CW = (1 << SW) - 1;

  logic          run_q;
  logic          byp_q;
  logic          div_q;
  logic [SW-1:0] s_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] mask;
  logic [CW-1:0] top_bit;
  logic          term;

  // mask has s_q low bits set; terminal count is all of them set
  for (genvar gi = 0; gi < CW; gi++) begin : g_mask
    assign mask[gi] = (int'(s_q) > gi);
  end

  assign top_bit = mask ^ (mask >> 1);
  assign cnt_nxt = cnt_q + 1'b1;
  assign term    = (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      byp_q <= 1'b0;
      div_q <= 1'b0;
      s_q   <= '0;
      cnt_q <= '0;
    end else if (halt_i) begin
      run_q <= 1'b0;
      byp_q <= 1'b0;
      div_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || term) begin
      run_q <= 1'b1;
      s_q   <= scale_i;
      cnt_q <= '0;
      byp_q <= (scale_i == '0);
      div_q <= (scale_i != '0);
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= ~|(cnt_nxt & top_bit);
    end
  end

  // divide by one: registered select gates the oscillator through
  assign clk_o = div_q | (byp_q & clk_i);
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int P_W     = 6,
  parameter int M_W     = 8,
  parameter int S_W     = 2,
  parameter int P_OFS   = 2,
  parameter int M_OFS   = 8,
  parameter int PD_SYNC = 2
) (
  input  logic           rst_ni,
  input  logic           ref_clk_i,
  input  logic           osc_clk_i,
  input  logic           pwrdn_i,
  input  logic [P_W-1:0] pre_sel_i,
  input  logic [M_W-1:0] fb_sel_i,
  input  logic [S_W-1:0] post_sel_i,
  output logic           ref_div_o,
  output logic           fb_div_o,
  output logic           out_clk_o
);
  localparam int PRW = pll_div_pkg::ratio_width(P_W, P_OFS);
  localparam int MRW = pll_div_pkg::ratio_width(M_W, M_OFS);

  logic           ref_halt;
  logic           osc_halt;
  logic [PRW-1:0] pre_ratio;
  logic [MRW-1:0] fb_ratio;

  assign pre_ratio = PRW'(pre_sel_i) + PRW'(P_OFS);
  assign fb_ratio  = MRW'(fb_sel_i) + MRW'(M_OFS);

  pll_pd_sync #(.STAGES(PD_SYNC)) u_ref_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .pd_i  (pwrdn_i),
    .halt_o(ref_halt)
  );

  pll_pd_sync #(.STAGES(PD_SYNC)) u_osc_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .pd_i  (pwrdn_i),
    .halt_o(osc_halt)
  );

  pll_int_div #(.RW(PRW)) u_pre_div (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .halt_i (ref_halt),
    .ratio_i(pre_ratio),
    .div_o  (ref_div_o)
  );

  pll_int_div #(.RW(MRW)) u_fb_div (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .halt_i (osc_halt),
    .ratio_i(fb_ratio),
    .div_o  (fb_div_o)
  );

  pll_post_scaler #(.SW(S_W)) u_post (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .halt_i (osc_halt),
    .scale_i(post_sel_i),
    .clk_o  (out_clk_o)
  );
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
  parameter int P_W   = 6,
  parameter int M_W   = 8,
  parameter int P_OFS = 2,
  parameter int M_OFS = 8
) (
  input logic rst_ni,
  input logic ref_clk_i,
  input logic osc_clk_i,
  input logic ref_halt,
  input logic osc_halt,
  input logic ref_div_o,
  input logic fb_div_o
);
  localparam int FB_HI_MAX  = pll_div_pkg::high_edges((1 << M_W) - 1 + M_OFS);
  localparam int REF_HI_MAX = pll_div_pkg::high_edges((1 << P_W) - 1 + P_OFS);

  int unsigned fb_hi_run;
  int unsigned ref_hi_run;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni)       fb_hi_run <= 0;
    else if (fb_div_o) fb_hi_run <= fb_hi_run + 1;
    else               fb_hi_run <= 0;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_hi_run <= 0;
    else if (ref_div_o) ref_hi_run <= ref_hi_run + 1;
    else                ref_hi_run <= 0;
  end

  a_r7_fb_pd_low: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    osc_halt |=> !fb_div_o);

  a_r7_ref_pd_low: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_halt |=> !ref_div_o);

  a_r8_ref_restart_high: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ($past(ref_halt) && !ref_halt) |=> ref_div_o);

  a_r8_fb_restart_high: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ($past(osc_halt) && !osc_halt) |=> fb_div_o);

  a_r5_fb_high_bound: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    fb_hi_run <= FB_HI_MAX);

  a_r5_ref_high_bound: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_hi_run <= REF_HI_MAX);
endmodule

bind pll_div_chain pll_div_chain_chk #(
  .P_W  (P_W),
  .M_W  (M_W),
  .P_OFS(P_OFS),
  .M_OFS(M_OFS)
) u_chk (
  .rst_ni   (rst_ni),
  .ref_clk_i(ref_clk_i),
  .osc_clk_i(osc_clk_i),
  .ref_halt (ref_halt),
  .osc_halt (osc_halt),
  .ref_div_o(ref_div_o),
  .fb_div_o (fb_div_o)
);

// File: tb/pll_div_chain_tb_top.sv
module pll_div_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 26;
  localparam int PD_SYNC    = 2;

  logic       rst_n   = 1'b0;
  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       pwrdn   = 1'b0;
  logic [5:0] p_sel   = '0;
  logic [7:0] m_sel   = '0;
  logic [1:0] s_sel   = 2'd1;
  logic       ref_div, fb_div, out_clk;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  pll_div_chain #(.PD_SYNC(PD_SYNC)) dut_i (
    .rst_ni    (rst_n),
    .ref_clk_i (ref_clk),
    .osc_clk_i (osc_clk),
    .pwrdn_i   (pwrdn),
    .pre_sel_i (p_sel),
    .fb_sel_i  (m_sel),
    .post_sel_i(s_sel),
    .ref_div_o (ref_div),
    .fb_div_o  (fb_div),
    .out_clk_o (out_clk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // sel: 0 feedback, 1 reference, 2 post output
  function automatic logic get_out(input int sel);
    if (sel == 0) return fb_div;
    if (sel == 1) return ref_div;
    return out_clk;
  endfunction

  task automatic edge_pos(input int sel);
    if (sel == 1) @(posedge ref_clk); else @(posedge osc_clk);
  endtask

  task automatic edge_neg(input int sel);
    if (sel == 1) @(negedge ref_clk); else @(negedge osc_clk);
  endtask

  // restart: halt, load fields while halted, release at an oscillator falling edge
  task automatic restart(input int m, input int p, input int s);
    @(negedge osc_clk) pwrdn = 1'b1;
    repeat (14) @(negedge osc_clk);
    m_sel = 8'(m); p_sel = 6'(p); s_sel = 2'(s);
    @(negedge osc_clk) pwrdn = 1'b0;
  endtask

  // called right after release; checks the start latency and the period shape
  task automatic check_div(input int sel, input int n, input int periods, input string req);
    int bad_pre = 0;
    int bad = 0;
    int bad_j = -1;
    int bad_v = 0;
    for (int e = 0; e < PD_SYNC; e++) begin
      edge_pos(sel); edge_neg(sel);
      if (get_out(sel) !== 1'b0) bad_pre++;
    end
    check(bad_pre == 0, "R8", $sformatf("low before start, sel %0d", sel), bad_pre, 0);
    for (int j = 0; j < n * periods; j++) begin
      logic exp_v;
      edge_pos(sel); edge_neg(sel);
      exp_v = ((j % n) < (n + 1) / 2);
      if (get_out(sel) !== exp_v) begin
        if (bad == 0) begin bad_j = j; bad_v = int'(get_out(sel)); end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("sel %0d n %0d first bad edge %0d", sel, n, bad_j),
          bad_v, (bad == 0) ? bad_v : int'(((bad_j % n) < (n + 1) / 2)));
  endtask

  // field change during the first period; new ratio applies from the second period
  task automatic check_change(input int sel, input int n0, input int n1, input int at_j,
                              input int new_field);
    int bad = 0;
    int bad_j = -1;
    repeat (PD_SYNC) begin edge_pos(sel); edge_neg(sel); end
    for (int j = 0; j < n0 + 2 * n1; j++) begin
      logic exp_v;
      edge_pos(sel); edge_neg(sel);
      exp_v = (j < n0) ? (j < (n0 + 1) / 2) : (((j - n0) % n1) < (n1 + 1) / 2);
      if (get_out(sel) !== exp_v) begin
        if (bad == 0) bad_j = j;
        bad++;
      end
      if (j == at_j) begin
        if (sel == 0) m_sel = 8'(new_field); else p_sel = 6'(new_field);
      end
    end
    check(bad == 0, "R6", $sformatf("ratio change sel %0d, mismatches", sel), bad, 0);
    if (bad != 0) $display("  first mismatch at edge %0d", bad_j);
  endtask

  task automatic check_bypass(input string req);
    int bad = 0;
    repeat (PD_SYNC + 2) @(posedge osc_clk);
    for (int k = 0; k < 12; k++) begin
      @(posedge osc_clk); #2;
      if (out_clk !== 1'b1) bad++;
      @(negedge osc_clk); #2;
      if (out_clk !== 1'b0) bad++;
    end
    check(bad == 0, req, "post output follows oscillator, mismatches", bad, 0);
  endtask

  task automatic t_reset();
    int bad = 0;
    m_sel = 8'd0; p_sel = 6'd0; s_sel = 2'd1;
    for (int k = 0; k < 6; k++) begin
      @(posedge osc_clk); #2;
      if ({ref_div, fb_div, out_clk} !== 3'b000) bad++;
      @(negedge osc_clk);
      if ({ref_div, fb_div, out_clk} !== 3'b000) bad++;
    end
    check(bad == 0, "R9", "outputs low in reset, mismatches", bad, 0);
    @(negedge osc_clk) rst_n = 1'b1;
    fork
      check_div(0, 8, 3, "R1");
      check_div(1, 2, 4, "R2");
      check_div(2, 2, 4, "R3");
    join
  endtask

  task automatic t_max_ratios();
    restart(255, 63, 3);
    fork
      check_div(0, 263, 2, "R1");
      check_div(1, 65, 2, "R2");
      check_div(2, 8, 4, "R3");
    join
  endtask

  task automatic t_odd_ratios();
    restart(1, 1, 2);
    fork
      check_div(0, 9, 3, "R5");
      check_div(1, 3, 4, "R5");
      check_div(2, 4, 4, "R3");
    join
  endtask

  task automatic t_example();
    restart(85, 42, 0);
    fork
      check_div(0, 93, 2, "R10");
      check_div(1, 44, 2, "R10");
      check_bypass("R4");
    join
  endtask

  task automatic t_change();
    restart(0, 5, 1);
    fork
      check_change(0, 8, 10, 3, 2);
      check_change(1, 7, 2, 2, 0);
    join
  endtask

  task automatic t_power_down();
    int bad_fb = 0;
    int bad_out = 0;
    int bad_ref = 0;
    restart(3, 3, 2);
    repeat (20) @(negedge osc_clk);
    pwrdn = 1'b1;
    repeat (14) @(negedge osc_clk);
    s_sel = 2'd0; m_sel = 8'd7; p_sel = 6'd9;
    fork
      for (int k = 0; k < 30; k++) begin
        @(posedge osc_clk); #2;
        if (out_clk !== 1'b0) bad_out++;
        if (fb_div !== 1'b0) bad_fb++;
        @(negedge osc_clk);
        if (out_clk !== 1'b0) bad_out++;
      end
      for (int k = 0; k < 12; k++) begin
        @(negedge ref_clk);
        if (ref_div !== 1'b0) bad_ref++;
        @(posedge ref_clk); #2;
        if (ref_div !== 1'b0) bad_ref++;
      end
    join
    check(bad_fb == 0, "R7", "feedback low in power-down, mismatches", bad_fb, 0);
    check(bad_ref == 0, "R7", "reference low in power-down, mismatches", bad_ref, 0);
    check(bad_out == 0, "R7", "post output low in power-down, mismatches", bad_out, 0);
    @(negedge osc_clk) pwrdn = 1'b0;
    fork
      check_div(0, 15, 2, "R1");
      check_div(1, 11, 2, "R2");
      check_bypass("R4");
    join
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    t_reset();
    t_max_ratios();
    t_odd_ratios();
    t_example();
    t_change();
    t_power_down();
    finish_test();
  end
endmodule